// File: doc/BRIEF.md
# Dual-Polynomial Receive CRC Checker

This block judges the integrity of a received serial packet. After the packet identifier has gone by, a controller raises the check enable. From then on, every valid destuffed bit goes into two serial CRC registers at once: a 5-bit one and a 16-bit one. Both shift registers use the same update as the CRC generators on the transmit side. Because the transmitted check field is part of the stream, a packet that arrived intact leaves each register holding a fixed, known residual. There is no need to compare against the received field.

The controller lowers the check enable at end of packet. It also drives a short-packet select, which marks packets carrying only a 16-bit body after the identifier. On the falling edge of the enable, the block checks one register against its residual. The short-packet select decides which one: the 5-bit register for short packets, the 16-bit register for all others. The block then raises a done flag, a pass flag and a flag naming the checker used. These flags hold until the next packet starts or the arm input is lowered. Lowering arm returns both registers to their preset value.

Top module: `rx_crc_dual`

## Requirements
- R1: While `rst_n` is low, and on any clock edge where `arm` is sampled low, `crc_good`, `chk_done` and `used_crc5` go to 0 and both CRC registers go to all ones.
- R2: The 5-bit register uses polynomial x^5+x^2+1 with an all-ones preset. Each bit is taken in receive order: the feedback is the register MSB XOR the bit, the register shifts left, and a feedback of 1 XORs in 00101.
- R3: The 16-bit register uses polynomial x^16+x^15+x^2+1 with an all-ones preset, in the same serial form as R2 and with XOR value 0x8005.
- R4: On a clock edge where `chk_en` is sampled high after being low, both registers are preset before that cycle's bit is taken. A new packet therefore never depends on the one before it.
- R5: A register advances only on edges where `arm`, `chk_en` and `rx_vld` are all high. Bits offered with `rx_vld` low or `chk_en` low change nothing.
- R6: End of packet is the first edge where `chk_en` is sampled low after being high. After that edge, `chk_done` reads 1.
- R7: When `short_pkt` is high at the end-of-packet edge, `used_crc5` is 1 and `crc_good` is 1 exactly when the 5-bit register equals 01100 (bit 4 down to bit 0).
- R8: When `short_pkt` is low at the end-of-packet edge, `used_crc5` is 0 and `crc_good` is 1 exactly when the 16-bit register equals 1000000000001101 (bit 15 down to bit 0).
- R9: After end of packet, `crc_good`, `chk_done` and `used_crc5` hold while `arm` stays high and `chk_en` stays low.
- R10: `crc_good` is never 1 while `chk_done` is 0. A rising `chk_en` clears all three flags on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Run control; low clears registers and flags |
| rx_bit | input | 1 | Destuffed serial data bit |
| rx_vld | input | 1 | rx_bit carries a valid bit this cycle |
| chk_en | input | 1 | High from after the identifier until end of packet |
| short_pkt | input | 1 | Packet is short; judge it with the 5-bit checker |
| crc_good | output | 1 | Selected checker found its residual |
| chk_done | output | 1 | A packet has been judged |
| used_crc5 | output | 1 | The judgement used the 5-bit checker |

## Verification
The checker assertions hold on every cycle for the flag protocol. They cover the clear on a low `arm`, the implication from pass to done, `chk_done` rising only one edge after `chk_en` falls, `used_crc5` tracking `short_pkt` at that edge, the flags holding once set, and the clear at packet start. Whether the registers compute the right polynomials, honour the valid and enable gating, and reach the residuals can only be shown by the bench's scenarios. Those scenarios send packets with correct check fields built in the bench, corrupted packets, packets with gaps and junk bits, packets judged with the wrong checker, and back-to-back packets.

// File: rtl/rx_crc_dual_pkg.sv
package rx_crc_dual_pkg;
   localparam int unsigned C5_W        = 5;
   localparam logic [4:0]  C5_POLY     = 5'b00101;
   localparam logic [4:0]  C5_PRESET   = 5'b11111;
   localparam logic [4:0]  C5_RESIDUAL = 5'b01100;

   localparam int unsigned C16_W        = 16;
   localparam logic [15:0] C16_POLY     = 16'h8005;
   localparam logic [15:0] C16_PRESET   = 16'hFFFF;
   localparam logic [15:0] C16_RESIDUAL = 16'h800D;

   typedef struct packed {
      logic done;
      logic good;
      logic sel5;
   } verdict_t;
endpackage

// File: rtl/crc_serial_lane.sv
module crc_serial_lane #(
   parameter int unsigned W        = 5,
   parameter logic [W-1:0] POLY     = '0,
   parameter logic [W-1:0] PRESET   = '1,
   parameter logic [W-1:0] RESIDUAL = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic start,
   input  logic step,
   input  logic din,
   output logic match
);
   localparam int unsigned MSB = W - 1;

   if (W < 2) begin : g_bad_w
      $error("crc_serial_lane: W must be at least 2");
   end

   logic [W-1:0] q;
   logic [W-1:0] base;
   logic [W-1:0] nxt;
   logic         fb;

   always_comb begin
      base = start ? PRESET : q;
      fb   = base[MSB] ^ din;
   end

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign nxt[i] = fb & POLY[i];
      end else begin : g_up
         assign nxt[i] = base[i-1] ^ (fb & POLY[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= PRESET;
      else if (clr)    q <= PRESET;
      else if (step)   q <= nxt;
      else if (start)  q <= PRESET;
   end

   assign match = (q == RESIDUAL);
endmodule

// File: rtl/crc_verdict.sv
module crc_verdict
   import rx_crc_dual_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     arm,
   input  logic     chk_en,
   input  logic     short_pkt,
   input  logic     match5,
   input  logic     match16,
   output logic     start,
   output verdict_t vd
);
   logic en_q;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_q <= 1'b0;
      else if (!arm) en_q <= 1'b0;
      else           en_q <= chk_en;
   end

   assign start = arm & chk_en & ~en_q;
   assign fall  = arm & en_q & ~chk_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vd <= '0;
      else if (!arm)   vd <= '0;
      else if (start)  vd <= '0;
      else if (fall) begin
         vd.done <= 1'b1;
         vd.sel5 <= short_pkt;
         vd.good <= short_pkt ? match5 : match16;
      end
   end
endmodule

// File: rtl/rx_crc_dual.sv
module rx_crc_dual
   import rx_crc_dual_pkg::*;
#(
   parameter int unsigned SW          = C5_W,
   parameter logic [SW-1:0] S_POLY     = C5_POLY,
   parameter logic [SW-1:0] S_PRESET   = C5_PRESET,
   parameter logic [SW-1:0] S_RESIDUAL = C5_RESIDUAL,
   parameter int unsigned LW          = C16_W,
   parameter logic [LW-1:0] L_POLY     = C16_POLY,
   parameter logic [LW-1:0] L_PRESET   = C16_PRESET,
   parameter logic [LW-1:0] L_RESIDUAL = C16_RESIDUAL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic rx_bit,
   input  logic rx_vld,
   input  logic chk_en,
   input  logic short_pkt,
   output logic crc_good,
   output logic chk_done,
   output logic used_crc5
);
   if (SW >= LW) begin : g_bad_order
      $error("rx_crc_dual: short checker must be narrower than long checker");
   end

   logic     start;
   logic     step;
   logic     clr;
   logic     m5;
   logic     m16;
   verdict_t vd;

   assign clr  = ~arm;
   assign step = arm & chk_en & rx_vld;

   crc_verdict u_vd (
      .clk(clk), .rst_n(rst_n), .arm(arm), .chk_en(chk_en),
      .short_pkt(short_pkt), .match5(m5), .match16(m16),
      .start(start), .vd(vd)
   );

   crc_serial_lane #(.W(SW), .POLY(S_POLY), .PRESET(S_PRESET), .RESIDUAL(S_RESIDUAL)) u_short (
      .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .step(step),
      .din(rx_bit), .match(m5)
   );

   crc_serial_lane #(.W(LW), .POLY(L_POLY), .PRESET(L_PRESET), .RESIDUAL(L_RESIDUAL)) u_long (
      .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .step(step),
      .din(rx_bit), .match(m16)
   );

   assign crc_good  = vd.good;
   assign chk_done  = vd.done;
   assign used_crc5 = vd.sel5;
endmodule

// File: rtl/rx_crc_dual_chk.sv
module rx_crc_dual_chk (
   input logic clk,
   input logic rst_n,
   input logic arm,
   input logic chk_en,
   input logic short_pkt,
   input logic crc_good,
   input logic chk_done,
   input logic used_crc5
);
   // R1
   arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> (!crc_good && !chk_done && !used_crc5));
   // R10
   good_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crc_good |-> chk_done);
   // R6
   done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chk_done) |-> (!$past(chk_en) && $past(chk_en, 2)));
   // R7
   sel_tracks_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chk_done) |-> (used_crc5 == $past(short_pkt)));
   // R9
   hold_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_done && !chk_en && arm) |=> ($stable(crc_good) && $stable(used_crc5) && chk_done));
   // R10
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(chk_en) && arm) |=> (!chk_done && !crc_good));
endmodule

bind rx_crc_dual rx_crc_dual_chk u_chk (
   .clk(clk), .rst_n(rst_n), .arm(arm), .chk_en(chk_en), .short_pkt(short_pkt),
   .crc_good(crc_good), .chk_done(chk_done), .used_crc5(used_crc5)
);

// File: tb/sim_rx_crc_dual.sv
module sim_rx_crc_dual;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0, rx_bit = 1'b0, rx_vld = 1'b0, chk_en = 1'b0, short_pkt = 1'b0;
   logic crc_good, chk_done, used_crc5;
   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   rx_crc_dual u0 (.*);

   task automatic check(input logic act, input logic exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] step5(input logic [4:0] r, input logic b);
      logic f = r[4] ^ b;
      return {r[3:0], 1'b0} ^ (f ? 5'b00101 : 5'b0);
   endfunction

   function automatic logic [15:0] step16(input logic [15:0] r, input logic b);
      logic f = r[15] ^ b;
      return {r[14:0], 1'b0} ^ (f ? 16'h8005 : 16'h0);
   endfunction

   function automatic logic [63:0] mk5(input logic [10:0] d);
      logic [63:0] p = '0;
      logic [4:0]  r = 5'h1F;
      for (int i = 0; i < 11; i++) begin p[i] = d[i]; r = step5(r, d[i]); end
      for (int k = 0; k < 5; k++) p[11+k] = ~r[4-k];
      return p;
   endfunction

   function automatic logic [63:0] mk16(input logic [31:0] d, input int nd);
      logic [63:0] p = '0;
      logic [15:0] r = 16'hFFFF;
      for (int i = 0; i < nd; i++) begin p[i] = d[i]; r = step16(r, d[i]); end
      for (int k = 0; k < 16; k++) p[nd+k] = ~r[15-k];
      return p;
   endfunction

   function automatic logic res5_ok(input logic [63:0] p, input int n);
      logic [4:0] r = 5'h1F;
      for (int i = 0; i < n; i++) r = step5(r, p[i]);
      return r == 5'b01100;
   endfunction

   task automatic send(input logic [63:0] p, input int n, input logic sh, input bit gaps);
      @(negedge clk);
      chk_en = 1'b1; short_pkt = sh;
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 3 == 1)) begin
            rx_vld = 1'b0; rx_bit = ~p[i];
            @(negedge clk);
         end
         rx_bit = p[i]; rx_vld = 1'b1;
         @(negedge clk);
      end
      rx_vld = 1'b0; chk_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check(crc_good, 1'b0, "R1 reset crc_good");
      check(chk_done, 1'b0, "R1 reset chk_done");
      check(used_crc5, 1'b0, "R1 reset used_crc5");
   endtask

   task automatic t_short_good();
      send(mk5(11'h5A3), 16, 1'b1, 1'b0);
      check(chk_done, 1'b1, "R6 short done");
      check(used_crc5, 1'b1, "R7 short sel");
      check(crc_good, 1'b1, "R2 R7 short good");
   endtask

   task automatic t_short_bad();
      logic [63:0] p = mk5(11'h13C);
      p[4] = ~p[4];
      send(p, 16, 1'b1, 1'b0);
      check(chk_done, 1'b1, "R6 short bad done");
      check(crc_good, 1'b0, "R7 short corrupted");
   endtask

   task automatic t_long_good();
      send(mk16(32'h00C3A512, 24), 40, 1'b0, 1'b0);
      check(used_crc5, 1'b0, "R8 long sel");
      check(crc_good, 1'b1, "R3 R8 long good");
      send(mk16(32'hDEADBEEF, 32), 48, 1'b0, 1'b0);
      check(crc_good, 1'b1, "R3 R8 long good 32");
   endtask

   task automatic t_long_bad();
      logic [63:0] p = mk16(32'h00C3A512, 24);
      p[30] = ~p[30];
      send(p, 40, 1'b0, 1'b0);
      check(crc_good, 1'b0, "R8 long corrupted");
   endtask

   task automatic t_gaps();
      send(mk16(32'h0071F00D, 24), 40, 1'b0, 1'b1);
      check(crc_good, 1'b1, "R5 gaps ignored");
   endtask

   task automatic t_hold_and_idle_bits();
      for (int i = 0; i < 20; i++) begin
         rx_vld = 1'b1; rx_bit = i[0];
         @(negedge clk);
      end
      rx_vld = 1'b0;
      check(chk_done, 1'b1, "R9 done holds");
      check(crc_good, 1'b1, "R9 good holds through en-low bits");
      send(mk5(11'h2F1), 16, 1'b1, 1'b0);
      check(crc_good, 1'b1, "R5 R4 en-low bits ignored");
   endtask

   task automatic t_wrong_checker();
      logic [63:0] p = mk16(32'h00C3A512, 24);
      send(p, 40, 1'b1, 1'b0);
      check(used_crc5, 1'b1, "R7 forced short sel");
      check(crc_good, res5_ok(p, 40), "R7 long packet judged by 5-bit");
   endtask

   task automatic t_restart();
      logic [63:0] p = mk16(32'h00ABCDEF, 24);
      p[0] = ~p[0];
      send(p, 40, 1'b0, 1'b0);
      check(crc_good, 1'b0, "R8 bad before restart");
      @(negedge clk);
      chk_en = 1'b1;
      @(negedge clk);
      check(chk_done, 1'b0, "R10 start clears done");
      chk_en = 1'b0;
      @(negedge clk);
      send(mk16(32'h00ABCDEF, 24), 40, 1'b0, 1'b0);
      check(crc_good, 1'b1, "R4 fresh preset after bad packet");
   endtask

   task automatic t_arm_clear();
      send(mk5(11'h0F0), 16, 1'b1, 1'b0);
      check(crc_good, 1'b1, "R7 good before arm drop");
      arm = 1'b0;
      @(negedge clk);
      check(crc_good, 1'b0, "R1 arm low crc_good");
      check(chk_done, 1'b0, "R1 arm low chk_done");
      check(used_crc5, 1'b0, "R1 arm low used_crc5");
      send(mk5(11'h0F0), 16, 1'b1, 1'b0);
      check(chk_done, 1'b0, "R5 nothing judged while disarmed");
      arm = 1'b1;
      @(negedge clk);
      send(mk5(11'h0F0), 16, 1'b1, 1'b0);
      check(crc_good, 1'b1, "R1 preset restored after arm");
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      t_reset();
      t_short_good();
      t_short_bad();
      t_long_good();
      t_long_bad();
      t_gaps();
      t_hold_and_idle_bits();
      t_wrong_checker();
      t_restart();
      t_arm_clear();
      summary();
      $finish;
   end
endmodule